// File: doc/BRIEF.md
# Compare-Match OS Timer Channel

A single 32-bit timer channel behind a simple word-addressed register port. Software programs a compare value and picks one of two modes. It then fires a start trigger, and can later fire a stop trigger. The two triggers are write-only registers. A separate read-only status bit shows whether the channel is running.

In interval mode the counter counts down from the compare value. It reloads at zero and produces an interrupt pulse every compare+1 clocks, so loading N-1 gives a tick every N clocks. In free-running mode the counter starts at zero and counts upward, wrapping at 2^32. It can be read at any time as a timestamp, and it pulses the interrupt one clock after it equals the compare value. A handler that stops the channel on that pulse gives one-shot behaviour.

Top module: `os_timer_chan`

## Requirements
- R1: The compare register (word address 0x00) is read/write and resets to 0. A write updates only the bytes whose `bus_be` bit is set, where bit i covers data bits 8i+7..8i.
- R2: A write to 0x14 with `bus_be[0]` set and data bit 0 set, made while the channel is idle, makes status bit 0 (read at 0x10) read 1 after that clock edge. A start write with data bit 0 clear has no effect, and so does a start write while the channel is running. In particular the counter is not reloaded.
- R3: A write to 0x18 with `bus_be[0]` and data bit 0 set, made while the channel is running, leaves the status at 1 after the write edge and clears it after the following edge. From then on the counter holds its value.
- R4: The control register at 0x20 holds a mode bit at bit 1. A value of 0 selects interval mode and 1 selects free-running mode. All other control bits read 0.
- R5: In interval mode the counter reads the compare value right after the start edge and then counts down by one per clock. It reloads the compare value on the clock after it reads 0. The interrupt pulses first compare+1 clocks after the start edge, and again every compare+1 clocks after that.
- R6: In free-running mode the counter (read-only at 0x04) reads 0 right after the start edge and rises by one per clock, modulo 2^32.
- R7: In free-running mode the interrupt pulses one clock after the counter equals the compare value, which is compare+1 clocks after the start edge. It does not pulse on other clocks.
- R8: Writes to the compare and control registers are ignored while the status bit reads 1.
- R9: After reset all registers read 0 and the interrupt is low. The interrupt stays low whenever the status bit is 0.
- R10: Writes to the counter address are ignored. Reads from unmapped word addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | One-clock interrupt pulse per event |

## Verification
Both modes are run with random compare values from a fixed seed. Directed cases cover compare 0, where interval mode fires every clock, and a compare of 1. Tracking the counter on every clock separates the down-count-and-reload pattern from the up-count pattern. Tracking the pulse positions tells a period of compare+1 apart from an off-by-one period of compare. Restart writes, writes to locked registers, partial byte writes and stop-on-interrupt are each followed by port reads. These reads show whether the counter was reloaded, whether the registers changed, and whether the status cleared after exactly two edges.

// File: rtl/os_timer_chan.sv
module os_timer_chan #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] W_CMP   = WA_W'(0);
  localparam logic [WA_W-1:0] W_CNT   = WA_W'(1);
  localparam logic [WA_W-1:0] W_STAT  = WA_W'(4);
  localparam logic [WA_W-1:0] W_START = WA_W'(5);
  localparam logic [WA_W-1:0] W_STOP  = WA_W'(6);
  localparam logic [WA_W-1:0] W_CTL   = WA_W'(8);

  logic [31:0] cmp_q, cnt_q;
  logic        en_q, mode_q, stop_pend_q, irq_q;

  wire [WA_W-1:0] word = bus_addr[ADDR_W-1:2];
  wire wr        = bus_sel & bus_we;
  wire trig_b0   = wr & bus_be[0] & bus_wdata[0];
  wire start_go  = trig_b0 & (word == W_START) & ~en_q;
  wire stop_hit  = trig_b0 & (word == W_STOP) & en_q;
  wire cfg_wr    = wr & ~en_q;
  wire event_now = mode_q ? (cnt_q == cmp_q) : (cnt_q == 32'd0);

  for (genvar b = 0; b < 4; b++) begin : g_cmp_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        cmp_q[8*b +: 8] <= 8'd0;
      else if (cfg_wr && word == W_CMP && bus_be[b])
        cmp_q[8*b +: 8] <= bus_wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= 1'b0;
      en_q        <= 1'b0;
      stop_pend_q <= 1'b0;
      cnt_q       <= 32'd0;
      irq_q       <= 1'b0;
    end else begin
      if (cfg_wr && word == W_CTL && bus_be[0])
        mode_q <= bus_wdata[1];
      stop_pend_q <= stop_hit;
      if (start_go)
        en_q <= 1'b1;
      else if (stop_pend_q)
        en_q <= 1'b0;
      if (start_go)
        cnt_q <= mode_q ? 32'd0 : cmp_q;
      else if (en_q)
        cnt_q <= mode_q ? cnt_q + 32'd1 : (event_now ? cmp_q : cnt_q - 32'd1);
      irq_q <= en_q & event_now;
    end
  end

  assign irq = irq_q & en_q;

  always_comb begin
    case (word)
      W_CMP:   bus_rdata = cmp_q;
      W_CNT:   bus_rdata = cnt_q;
      W_STAT:  bus_rdata = {31'd0, en_q};
      W_CTL:   bus_rdata = {30'd0, mode_q, 1'b0};
      default: bus_rdata = 32'd0;
    endcase
  end

  assert_start_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_b0 && word == W_START && !en_q) |=> en_q);
  assert_stop_two_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_b0 && word == W_STOP && en_q) |=> (en_q ##1 !en_q));
  assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(cmp_q) && $stable(mode_q)));
  assert_interval_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !mode_q) |-> (cnt_q == cmp_q));
  assert_freerun_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q && !stop_pend_q) |=> (cnt_q == $past(cnt_q) + 32'd1));
  assert_freerun_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && mode_q) |-> (cnt_q == cmp_q + 32'd1));
  assert_idle_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !start_go) |=> $stable(cnt_q));
endmodule

// File: tb/os_timer_chan_bench.sv
module os_timer_chan_bench;
  logic clk = 0, rst_n = 0, bus_sel = 0, bus_we = 0;
  logic [5:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int n_run = 0, n_fail = 0, cyc = 0;

  os_timer_chan u_os_timer_chan (.clk, .rst_n, .bus_sel, .bus_we, .bus_addr,
    .bus_be, .bus_wdata, .bus_rdata, .irq);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: act=%0d expected below 150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic exp_irq(input logic mode, input int c, input int i);
    if (mode) return i == c + 1;
    return (i >= c + 1) && ((i - (c + 1)) % (c + 1) == 0);
  endfunction

  function automatic logic [31:0] exp_cnt(input logic mode, input int c, input int i);
    if (mode) return i;
    return c - (i % (c + 1));
  endfunction

  task automatic stop_chan(input string req);
    logic [31:0] d;
    wr(6'h18, 1, 4'b0001);
    rd(6'h10, d); chk({req, " R3 status after first edge"}, d, 1);
    @(negedge clk);
    rd(6'h10, d); chk({req, " R3 status after second edge"}, d, 0);
  endtask

  task automatic run_mode(input logic mode, input int c, input int cycles);
    logic [31:0] d;
    int bad_cnt = 0, bad_irq = 0;
    logic [31:0] bc_act = 0, bc_exp = 0;
    int bi = -1;
    wr(6'h20, {30'd0, mode, 1'b0}, 4'b0001);
    wr(6'h00, c, 4'b1111);
    wr(6'h14, 1, 4'b0001);
    for (int i = 0; i <= cycles; i++) begin
      if (i > 0) @(negedge clk);
      rd(6'h04, d);
      if (d !== exp_cnt(mode, c, i)) begin
        if (bad_cnt == 0) begin bc_act = d; bc_exp = exp_cnt(mode, c, i); end
        bad_cnt++;
      end
      if (irq !== exp_irq(mode, c, i)) begin
        if (bad_irq == 0) bi = i;
        bad_irq++;
      end
    end
    if (mode) begin
      chk("R6 free-run count sequence", bc_act, bc_exp);
      chk("R7 free-run irq first mismatch index (-1 none)", bi, -1);
    end else begin
      chk("R5 interval count sequence", bc_act, bc_exp);
      chk("R5 interval irq first mismatch index (-1 none)", bi, -1);
    end
    stop_chan(mode ? "free-run" : "interval");
  endtask

  initial begin
    logic [31:0] d, a;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(6'h00, d); chk("R9 reset compare", d, 0);
    rd(6'h04, d); chk("R9 reset counter", d, 0);
    rd(6'h10, d); chk("R9 reset status", d, 0);
    rd(6'h20, d); chk("R9 reset control", d, 0);
    chk("R9 reset irq", irq, 0);

    wr(6'h00, 32'hAABBCCDD, 4'b1111);
    wr(6'h00, 32'h11223344, 4'b0101);
    rd(6'h00, d); chk("R1 byte-enable merge", d, 32'hAA22CC44);
    wr(6'h20, 32'hFF, 4'b0001);
    rd(6'h20, d); chk("R4 control only mode bit", d, 2);
    wr(6'h20, 0, 4'b0001);
    rd(6'h20, d); chk("R4 control cleared", d, 0);
    wr(6'h04, 32'h55, 4'b1111);
    rd(6'h04, d); chk("R10 counter write ignored", d, 0);
    rd(6'h0C, d); chk("R10 unmapped read", d, 0);

    wr(6'h14, 2, 4'b0001);
    rd(6'h10, d); chk("R2 start with bit0 clear ignored", d, 0);

    run_mode(0, 0, 8);
    run_mode(0, 1, 10);
    run_mode(1, 0, 6);

    // R8 lock, R2 restart ignored, in free-run
    wr(6'h20, 2, 4'b0001);
    wr(6'h00, 50, 4'b1111);
    wr(6'h14, 1, 4'b0001);
    repeat (4) @(negedge clk);
    wr(6'h00, 7, 4'b1111);
    rd(6'h00, d); chk("R8 compare locked while running", d, 50);
    wr(6'h20, 0, 4'b0001);
    rd(6'h20, d); chk("R8 control locked while running", d, 2);
    wr(6'h14, 1, 4'b0001);
    rd(6'h04, d); chk("R2 restart does not reload counter", d, 7);
    stop_chan("lock");
    rd(6'h04, a);
    n_run++;
    repeat (5) begin
      @(negedge clk);
      if (irq !== 1'b0) begin n_fail++; $display("FAIL R9 irq while disabled: act=1 exp=0"); end
    end
    rd(6'h04, d); chk("R3 counter frozen after stop", d, a);

    // one-shot: stop on the interrupt
    wr(6'h00, 3, 4'b1111);
    wr(6'h14, 1, 4'b0001);
    while (irq !== 1'b1) @(negedge clk);
    stop_chan("one-shot R7");
    repeat (10) @(negedge clk);
    chk("R9 no irq after one-shot stop", irq, 0);

    for (int k = 0; k < 12; k++) begin
      run_mode(k[0], $urandom_range(2, 30), 70);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule